// File: doc/BRIEF.md
# 8x8 Two-Dimensional DCT Engine

This block turns an 8x8 tile of signed samples into its two-dimensional discrete cosine transform, or takes such a tile of coefficients back to samples. A per-block direction input chooses between the two. The block splits the 2-D work into two 8-point passes: the first pass works along the rows and the second along the columns. Both passes use one shared one-dimensional unit, and a 64-entry transpose buffer sits between them.

The 64 values of a tile enter in row-major order over a valid/ready handshake, one per cycle. The direction is captured with the first value of each tile. The 64 results leave through a one-entry output register, also under valid/ready, in row-major order, with a last marker on the final value. The input buffer is freed as soon as the row pass has read it. The next tile can therefore load while the current tile's column pass is still producing results.

Basis weights are 12-bit signed with 11 fractional bits. The row pass keeps 3 extra fractional bits in the transpose buffer. Each pass rounds to nearest, with halves going up. Every result is thus within one LSB of the exact real-valued transform.

Top module: `dct8x8_engine`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A value is taken when in_valid and in_ready are both high at a clock edge. Values fill the tile in row-major order, so the i-th value taken is row i/8, column i%8. in_ready stays high until 64 values have been taken. mode_inv is sampled only with the first value of a tile (0 = forward, 1 = inverse), and changes on later values of that tile have no effect.
- R3: In forward mode, output (u,v) is within 1 of the sum over m,n of c(u,m)·c(v,n)·x[m][n]. Here c(k,n) = s(k)·cos((2n+1)kπ/16), with s(0) = sqrt(1/8) and s(k) = sqrt(2/8) otherwise.
- R4: In inverse mode, output (p,q) is within 1 of the sum over u,v of c(u,p)·c(v,q)·X[u][v].
- R5: A forward tile whose values are all equal to a constant d gives output (0,0) within 1 of 8·d, and exactly 0 at the other 63 positions.
- R6: Feeding a forward result tile back in inverse mode reproduces the original samples within ±1, for samples in [-31, 31].
- R7: Results leave in row-major order, 64 per tile. out_last is 1 on the 64th result of each tile and 0 on every other result.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values on the next cycle, and no result is lost or repeated.
- R9: If the engine is idle when a tile's 64th value is taken, in_ready stays low for exactly 65 cycles, which covers one start cycle and the 64-cycle row pass. Once the column pass starts, a whole next tile can be taken even if no result of the previous tile has been read yet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_inv | input | 1 | Direction for the tile: 0 forward, 1 inverse; sampled with the tile's first value |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Engine can take an input value |
| in_data | input | IN_W (9) | Signed input sample or coefficient |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | IN_W+4 (13) | Signed result |
| out_last | output | 1 | Marks the 64th result of a tile |

## Verification
Basis-index and transpose-addressing faults show up in the first tile. A misplaced read or weight moves energy into wrong positions, so DC and random tiles disagree with the real-valued reference at specific (u,v) within 64 results. Rounding or fraction-alignment faults give results off by a factor or by more than one LSB, and the round trip fails. A wrong load count or a stuck buffer-full flag is visible at in_ready within a tile: it gives a wrong low-time after the 64th value, a second tile that cannot load during backpressure, or out_last on the wrong result. Output-register faults appear on the first stalled cycle as changed data under backpressure.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int DCT_N     = 8;
    localparam int COEF_W    = 12;
    localparam int COEF_FRAC = 11;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2
    } phase_e;

    // half-scale cosine of m*pi/16 for m = 0..8, 11 fractional bits
    function automatic coef_t half_cos(input logic [4:0] m);
        case (m)
            5'd0:    half_cos = 12'sd1024;
            5'd1:    half_cos = 12'sd1004;
            5'd2:    half_cos = 12'sd946;
            5'd3:    half_cos = 12'sd851;
            5'd4:    half_cos = 12'sd724;
            5'd5:    half_cos = 12'sd569;
            5'd6:    half_cos = 12'sd392;
            5'd7:    half_cos = 12'sd200;
            default: half_cos = 12'sd0;
        endcase
    endfunction

    // scaled basis weight for frequency k and position n
    function automatic coef_t basis(input logic [2:0] k, input logic [2:0] n);
        logic [6:0] prod;
        logic [4:0] m;
        logic       neg;
        coef_t      v;
        prod = 7'({n, 1'b1}) * 7'(k);
        m    = prod[4:0];
        neg  = 1'b0;
        if (m > 5'd16) begin
            m = 5'd0 - m;
        end
        if (m > 5'd8) begin
            neg = 1'b1;
            m   = 5'd16 - m;
        end
        v = half_cos(m);
        if (k == 3'd0) begin
            basis = 12'sd724;
        end else begin
            basis = neg ? -v : v;
        end
    endfunction

endpackage

// File: rtl/dct_coef_sel.sv
module dct_coef_sel
    import dct_pkg::*;
(
    input  logic [2:0] idx,
    input  logic       inv,
    output coef_t      coef [DCT_N]
);

    // forward: weights of output frequency idx over positions j
    // inverse: weights of output position idx over frequencies j
    for (genvar j = 0; j < DCT_N; j++) begin : g_coef
        localparam logic [2:0] J = j[2:0];
        assign coef[j] = inv ? basis(J, idx) : basis(idx, J);
    end

endmodule

// File: rtl/dct_buf64.sv
module dct_buf64 #(
    parameter int W        = 14,
    parameter bit COL_READ = 1'b0
) (
    input  logic                clk,
    input  logic                we,
    input  logic [5:0]          waddr,
    input  logic signed [W-1:0] wdata,
    input  logic [2:0]          line,
    output logic signed [W-1:0] rd [8]
);

    logic signed [W-1:0] mem [64];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar j = 0; j < 8; j++) begin : g_rd
        localparam logic [2:0] J = j[2:0];
        if (COL_READ) begin : g_col
            assign rd[j] = mem[{J, line}];
        end else begin : g_row
            assign rd[j] = mem[{line, J}];
        end
    end

endmodule

// File: rtl/dct_dot8.sv
module dct_dot8
    import dct_pkg::*;
#(
    parameter int SW    = 14,
    parameter int ACC_W = 29,
    parameter int RES_W = 14,
    parameter int SH_A  = 8,
    parameter int SH_B  = 14
) (
    input  logic signed [SW-1:0]    smp  [DCT_N],
    input  coef_t                   coef [DCT_N],
    input  logic                    sel_b,
    output logic signed [RES_W-1:0] res
);

    localparam logic signed [ACC_W-1:0] HALF_A = ACC_W'(1) <<< (SH_A - 1);
    localparam logic signed [ACC_W-1:0] HALF_B = ACC_W'(1) <<< (SH_B - 1);

    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int j = 0; j < DCT_N; j++) begin
            acc = acc + ACC_W'(smp[j]) * ACC_W'(coef[j]);
        end
        if (sel_b) begin
            res = RES_W'((acc + HALF_B) >>> SH_B);
        end else begin
            res = RES_W'((acc + HALF_A) >>> SH_A);
        end
    end

endmodule

// File: rtl/dct8x8_engine.sv
module dct8x8_engine
    import dct_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter int MID_FRAC = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_inv,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic signed [IN_W+3:0] out_data,
    output logic                   out_last
);

    localparam int OUT_W  = IN_W + 4;
    localparam int MID_W  = IN_W + 2 + MID_FRAC;
    localparam int ACC_W  = MID_W + COEF_W + 3;
    localparam int SH_ROW = COEF_FRAC - MID_FRAC;
    localparam int SH_COL = COEF_FRAC + MID_FRAC;
    localparam int CNT_W  = 6;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DCT_N * DCT_N - 1);

    typedef struct packed {
        logic [CNT_W-1:0]        ld_cnt;
        logic                    ld_full;
        logic                    ld_inv;
        phase_e                  ph;
        logic [CNT_W-1:0]        step;
        logic                    run_inv;
        logic                    o_valid;
        logic                    o_last;
        logic signed [OUT_W-1:0] o_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                    take;
    logic                    row_we;
    logic                    use_col;
    logic [2:0]              coef_idx;
    logic signed [IN_W-1:0]  irow [DCT_N];
    logic signed [MID_W-1:0] xcol [DCT_N];
    logic signed [MID_W-1:0] smp  [DCT_N];
    coef_t                   cf   [DCT_N];
    logic signed [MID_W-1:0] dot_res;

    // input tile, read one row at a time by the row pass
    dct_buf64 #(.W(IN_W), .COL_READ(1'b0)) u_ibuf (
        .clk   (clk),
        .we    (take),
        .waddr (ctl_q.ld_cnt),
        .wdata (in_data),
        .line  (ctl_q.step[5:3]),
        .rd    (irow)
    );

    // transpose buffer: row-major writes, column reads
    dct_buf64 #(.W(MID_W), .COL_READ(1'b1)) u_xbuf (
        .clk   (clk),
        .we    (row_we),
        .waddr (ctl_q.step),
        .wdata (dot_res),
        .line  (ctl_q.step[2:0]),
        .rd    (xcol)
    );

    dct_coef_sel u_coef (
        .idx  (coef_idx),
        .inv  (ctl_q.run_inv),
        .coef (cf)
    );

    dct_dot8 #(
        .SW    (MID_W),
        .ACC_W (ACC_W),
        .RES_W (MID_W),
        .SH_A  (SH_ROW),
        .SH_B  (SH_COL)
    ) u_dot (
        .smp   (smp),
        .coef  (cf),
        .sel_b (use_col),
        .res   (dot_res)
    );

    always_comb begin
        take     = in_valid && !ctl_q.ld_full;
        row_we   = (ctl_q.ph == PH_ROW);
        use_col  = (ctl_q.ph == PH_COL);
        coef_idx = use_col ? ctl_q.step[5:3] : ctl_q.step[2:0];
        for (int j = 0; j < DCT_N; j++) begin
            smp[j] = use_col ? xcol[j] : MID_W'(irow[j]);
        end
    end

    always_comb begin
        ctl_d = ctl_q;

        if (take) begin
            if (ctl_q.ld_cnt == '0) begin
                ctl_d.ld_inv = mode_inv;
            end
            ctl_d.ld_cnt = ctl_q.ld_cnt + 1'b1;
            if (ctl_q.ld_cnt == LAST_IDX) begin
                ctl_d.ld_full = 1'b1;
            end
        end

        if (ctl_q.o_valid && out_ready) begin
            ctl_d.o_valid = 1'b0;
        end

        case (ctl_q.ph)
            PH_IDLE: begin
                if (ctl_q.ld_full) begin
                    ctl_d.ph      = PH_ROW;
                    ctl_d.step    = '0;
                    ctl_d.run_inv = ctl_q.ld_inv;
                end
            end
            PH_ROW: begin
                ctl_d.step = ctl_q.step + 1'b1;
                if (ctl_q.step == LAST_IDX) begin
                    ctl_d.ph      = PH_COL;
                    ctl_d.ld_full = 1'b0;
                end
            end
            PH_COL: begin
                if (!ctl_q.o_valid || out_ready) begin
                    ctl_d.o_valid = 1'b1;
                    ctl_d.o_data  = OUT_W'(dot_res);
                    ctl_d.o_last  = (ctl_q.step == LAST_IDX);
                    ctl_d.step    = ctl_q.step + 1'b1;
                    if (ctl_q.step == LAST_IDX) begin
                        ctl_d.ph = PH_IDLE;
                    end
                end
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready  = !ctl_q.ld_full;
    assign out_valid = ctl_q.o_valid;
    assign out_data  = ctl_q.o_data;
    assign out_last  = ctl_q.o_last;

endmodule

// File: rtl/dct8x8_engine_chk.sv
module dct8x8_engine_chk #(
    parameter int OUT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [OUT_W-1:0] out_data
);

    logic [5:0] seen_in;
    logic [5:0] seen_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_in  <= '0;
            seen_out <= '0;
        end else begin
            if (in_valid && in_ready) begin
                seen_in <= seen_in + 1'b1;
            end
            if (out_valid && out_ready) begin
                seen_out <= seen_out + 1'b1;
            end
        end
    end

    // R2
    partial_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_in != 6'd0) |-> in_ready);

    // R9
    full_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && seen_in == 6'd63) |=> !in_ready);

    // R7
    last_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (out_last == (seen_out == 6'd63)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind dct8x8_engine dct8x8_engine_chk #(.OUT_W(IN_W + 4)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data)
);

// File: tb/dct8x8_engine_bench.sv
module dct8x8_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 9;
    localparam int OUT_W      = IN_W + 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    mode_inv = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic signed [OUT_W-1:0] out_data;
    logic                    out_last;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    int  rdy_mode = 0;
    int  res [0:1023];
    int  res_n = 0;
    int  stage [64];
    int  keep [64];
    real refv [64];
    real ref_a [64];
    int unsigned seed = 32'h1234_5678;

    bit  stall_prev = 1'b0;
    int  stall_data = 0;
    bit  stall_last = 1'b0;

    dct8x8_engine u_dct8x8_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_inv  (mode_inv),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input bit ok, input int act, input real expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0f", tag, act, expv);
        end
    endtask

    // output side: ready pattern, capture, stall and last-flag checks
    always @(negedge clk) begin
        cyc++;
        if (stall_prev) begin
            chk("R8 stalled result changed", out_valid && (int'(out_data) == stall_data)
                && (out_last == stall_last), int'(out_data), real'(stall_data));
        end
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        if (out_valid && out_ready) begin
            res[res_n] = int'(out_data);
            chk("R7 out_last position", out_last == ((res_n % 64) == 63),
                int'(out_last), real'((res_n % 64) == 63));
            res_n++;
        end
        stall_prev = out_valid && !out_ready;
        stall_data = int'(out_data);
        stall_last = out_last;
    end

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 32'd1103515245 + 32'd12345;
        return lo + int'((seed >> 8) % 32'(hi - lo + 1));
    endfunction

    function automatic real cb(input int k, input int n);
        real s;
        s = (k == 0) ? $sqrt(1.0 / 8.0) : $sqrt(2.0 / 8.0);
        return s * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0);
    endfunction

    task automatic make_ref(input bit inv);
        for (int o = 0; o < 64; o++) begin
            real s = 0.0;
            for (int i = 0; i < 64; i++) begin
                real w;
                if (inv) w = cb(i / 8, o / 8) * cb(i % 8, o % 8);
                else     w = cb(o / 8, i / 8) * cb(o % 8, i % 8);
                s = s + w * real'(stage[i]);
            end
            refv[o] = s;
        end
    endtask

    task automatic send_stage(input bit inv, input bit flip);
        for (int i = 0; i < 64; i++) begin
            in_valid = 1'b1;
            in_data  = stage[i][IN_W-1:0];
            mode_inv = (flip && i > 0) ? ~inv : inv;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        mode_inv = 1'b0;
    endtask

    task automatic wait_res(input int n);
        while (res_n < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_vs_ref(input string tag, input int base, input real r [64]);
        for (int i = 0; i < 64; i++) begin
            real d = real'(res[base + i]) - r[i];
            chk(tag, (d <= 1.0) && (d >= -1.0), res[base + i], r[i]);
        end
    endtask

    task automatic t_reset();
        chk("R1 in_ready after reset", in_ready == 1'b1, int'(in_ready), 1.0);
        chk("R1 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0.0);
    endtask

    task automatic t_dc(input int d);
        int base = res_n;
        for (int i = 0; i < 64; i++) stage[i] = d;
        send_stage(1'b0, 1'b0);
        wait_res(base + 64);
        chk("R5 DC term", (res[base] - 8 * d <= 1) && (8 * d - res[base] <= 1),
            res[base], real'(8 * d));
        for (int i = 1; i < 64; i++) begin
            chk("R5 AC term zero", res[base + i] == 0, res[base + i], 0.0);
        end
    endtask

    // R2 and R3: forward tile with mode_inv toggled after the first value
    task automatic t_fwd_random();
        int base = res_n;
        for (int i = 0; i < 64; i++) stage[i] = rnd(-256, 255);
        make_ref(1'b0);
        send_stage(1'b0, 1'b1);
        wait_res(base + 64);
        check_vs_ref("R3 R2 forward tile", base, refv);
    endtask

    task automatic t_inv_random();
        int base = res_n;
        for (int i = 0; i < 64; i++) stage[i] = rnd(-256, 255);
        make_ref(1'b1);
        send_stage(1'b1, 1'b1);
        wait_res(base + 64);
        check_vs_ref("R4 inverse tile", base, refv);
    endtask

    task automatic t_roundtrip();
        int base = res_n;
        for (int i = 0; i < 64; i++) begin
            keep[i]  = rnd(-31, 31);
            stage[i] = keep[i];
        end
        send_stage(1'b0, 1'b0);
        wait_res(base + 64);
        for (int i = 0; i < 64; i++) stage[i] = res[base + i];
        send_stage(1'b1, 1'b0);
        wait_res(base + 128);
        for (int i = 0; i < 64; i++) begin
            int d = res[base + 64 + i] - keep[i];
            chk("R6 round trip", (d <= 1) && (d >= -1), res[base + 64 + i], real'(keep[i]));
        end
    endtask

    task automatic t_backpressure();
        int base = res_n;
        rdy_mode = 1;
        for (int i = 0; i < 64; i++) stage[i] = rnd(-256, 255);
        make_ref(1'b0);
        send_stage(1'b0, 1'b0);
        wait_res(base + 64);
        rdy_mode = 0;
        chk("R8 result count under stalls", res_n == base + 64, res_n - base, 64.0);
        check_vs_ref("R8 values under stalls", base, refv);
    endtask

    task automatic t_ready_timing();
        int lows = 0;
        int base = res_n;
        for (int i = 0; i < 64; i++) stage[i] = rnd(-100, 100);
        send_stage(1'b0, 1'b0);
        while (!in_ready) begin
            lows++;
            @(negedge clk);
        end
        chk("R9 in_ready low time", lows == 65, lows, 65.0);
        wait_res(base + 64);
    endtask

    task automatic t_overlap();
        int base = res_n;
        rdy_mode = 2;
        for (int i = 0; i < 64; i++) stage[i] = rnd(-256, 255);
        make_ref(1'b0);
        for (int i = 0; i < 64; i++) ref_a[i] = refv[i];
        send_stage(1'b0, 1'b0);
        for (int i = 0; i < 64; i++) stage[i] = rnd(-200, 200);
        make_ref(1'b1);
        send_stage(1'b1, 1'b0);
        chk("R9 next tile loaded with results pending", res_n == base, res_n - base, 0.0);
        rdy_mode = 0;
        wait_res(base + 128);
        check_vs_ref("R9 first tile after overlap", base, ref_a);
        check_vs_ref("R9 second tile after overlap", base + 64, refv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", res_n, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dc(100);
        t_dc(-256);
        t_fwd_random();
        t_inv_random();
        t_roundtrip();
        t_backpressure();
        t_ready_timing();
        t_overlap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule